// File: doc/BRIEF.md
# Exponential-of-Sine Evaluator

This block is a fully pipelined fixed-point datapath that approximates e^sin(x) for a signed 16-bit sample. It evaluates the truncated series P(x) = 1 + x + x²/2 − x⁴/8 − x⁵/15 − x⁶/240. The x³ term is absent. The series is computed in nested (Horner) form, one registered multiply-add stage per coefficient, followed by one rounding and saturation stage. A new sample may enter on every clock cycle.

The stream edges carry a valid strobe only. There is no ready signal and no back-pressure. The block accepts a sample on every cycle in which `in_vld` is high. The consumer must take every result in the cycle in which `out_vld` is high, because results are never held or repeated. Accuracy is guaranteed for inputs with a magnitude below pi/2. Larger inputs still produce a defined, saturated result.

Top module: `exp_sine_eval`

## Requirements
- R1: `in_x` and `out_y` are two's-complement numbers with 13 fraction bits, so raw value 8192 (0x2000) stands for 1.0. For x = 1.0 the output is within 2 LSB of round(P(1.0)·8192) = 18876.
- R2: For every raw input with |in_x| ≤ 12867 (|x| < pi/2), `out_y` is within 2 LSB of round(P(x)·8192), where P(x) = 1 + x + x²/2 − x⁴/8 − x⁵/15 − x⁶/240.
- R3: An input of exactly 0 produces exactly 0x2000 (1.0).
- R4: When the polynomial value falls outside the output range, the output saturates rather than wrapping. Input 0x8000 (−4.0) gives 0x7FFF, and input 0x7FFF (≈ +4.0) gives 0x8000. A non-negative internal result never yields a negative output.
- R5: `out_vld` is high exactly in the cycle that follows the seventh rising edge counted from, and including, the edge that captured `in_vld` high. Gaps in `in_vld` reappear unchanged at `out_vld`.
- R6: Samples presented on consecutive cycles are all accepted, and they produce results on consecutive cycles in the same order.
- R7: A synchronous active-high `rst` discards every sample in flight. `out_vld` stays low after reset until a sample accepted after reset has crossed the pipeline.
- R8: For |x| < pi/2 every result lies between 0x0A00 (0.3125) and 0x5A00 (2.8125).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register samples on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_vld | input | 1 | Input sample strobe |
| in_x | input | 16 | Signed input sample with 13 fraction bits |
| out_vld | output | 1 | Result strobe, seven edges after the capture edge |
| out_y | output | 16 | Signed result with 13 fraction bits, rounded and saturated |

## Verification
On every cycle, the assertions check four things: the seven-edge strobe latency, the exact 1.0 result for a zero input, the result window for in-range inputs, and the quiet output after reset. Each multiply-add stage also asserts that a zero sample passes its coefficient through unchanged, and the rounding stage asserts that a non-negative sum never turns negative. Only the bench's sweep of every in-range input against a real-valued evaluation of the series can show the error bound. The bench also shows the saturation codes at the two extreme inputs, and the loss of in-flight samples when reset arrives mid-stream.

// File: rtl/eps_pkg.sv
package eps_pkg;

  // highest power of x in the series
  localparam int POLY_ORDER = 6;

  // coefficient of x^k, quantized with round-to-nearest to `frac` fraction bits
  function automatic longint coef_q(input int k, input int frac);
    longint num;
    longint den;
    longint mag;
    case (k)
      0:       begin num = 1;  den = 1;   end
      1:       begin num = 1;  den = 1;   end
      2:       begin num = 1;  den = 2;   end
      3:       begin num = 0;  den = 1;   end
      4:       begin num = -1; den = 8;   end
      5:       begin num = -1; den = 15;  end
      default: begin num = -1; den = 240; end
    endcase
    mag = (((num < 0) ? -num : num) * (64'sd1 <<< frac) + den / 2) / den;
    return (num < 0) ? -mag : mag;
  endfunction

endpackage

// File: rtl/eps_mac_stage.sv
module eps_mac_stage #(
  parameter int ACC_W     = 26,
  parameter int DATA_W    = 16,
  parameter int DATA_FRAC = 13,
  parameter logic signed [ACC_W-1:0] COEF = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld_i,
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic                     vld_o,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam int PROD_W = ACC_W + DATA_W;
  localparam logic signed [PROD_W-1:0] HI = (PROD_W'(1) <<< (ACC_W - 1)) - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] LO = -HI - PROD_W'(1);

  logic signed [PROD_W-1:0] a_ext, x_ext, prod, sum;
  logic signed [ACC_W-1:0]  clamped;

  always_comb begin
    a_ext = PROD_W'(acc_i);
    x_ext = PROD_W'(x_i);
    prod  = a_ext * x_ext;
    sum   = (prod >>> DATA_FRAC) + PROD_W'(COEF);
    if (sum > HI)      clamped = HI[ACC_W-1:0];
    else if (sum < LO) clamped = LO[ACC_W-1:0];
    else               clamped = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
    acc_o <= clamped;
  end

  AST_ZERO_TAKES_COEF: assert property (@(posedge clk) disable iff (rst)
    (vld_i && x_i == '0) |=> (acc_o == COEF)); // R3

endmodule

// File: rtl/eps_round_sat.sv
module eps_round_sat #(
  parameter int ACC_W     = 26,
  parameter int ACC_FRAC  = 20,
  parameter int DATA_W    = 16,
  parameter int DATA_FRAC = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     vld_i,
  input  logic signed [ACC_W-1:0]  acc_i,
  output logic                     vld_o,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int SH  = ACC_FRAC - DATA_FRAC;
  localparam int EXT = ACC_W + 1;
  localparam logic signed [EXT-1:0] HALF  = EXT'(1) <<< (SH - 1);
  localparam logic signed [EXT-1:0] Y_MAX = (EXT'(1) <<< (DATA_W - 1)) - EXT'(1);
  localparam logic signed [EXT-1:0] Y_MIN = -Y_MAX - EXT'(1);

  logic signed [EXT-1:0]    rnd;
  logic signed [DATA_W-1:0] sat;

  always_comb begin
    rnd = (EXT'(acc_i) + HALF) >>> SH;
    if (rnd > Y_MAX)      sat = Y_MAX[DATA_W-1:0];
    else if (rnd < Y_MIN) sat = Y_MIN[DATA_W-1:0];
    else                  sat = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
    y_o <= sat;
  end

  AST_NO_SIGN_WRAP: assert property (@(posedge clk) disable iff (rst)
    (vld_i && !acc_i[ACC_W-1]) |=> !y_o[DATA_W-1]); // R4

endmodule

// File: rtl/exp_sine_eval.sv
module exp_sine_eval #(
  parameter int DATA_W    = 16,
  parameter int DATA_FRAC = 13,
  parameter int ACC_INT   = 6,
  parameter int ACC_FRAC  = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic signed [DATA_W-1:0] in_x,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_y
);
  localparam int NSTAGE = eps_pkg::POLY_ORDER;
  localparam int ACC_W  = ACC_INT + ACC_FRAC;
  localparam int LAT    = NSTAGE + 1;
  localparam int CNT_W  = $clog2(LAT + 1);
  localparam logic signed [DATA_W-1:0] ONE    = DATA_W'(1) <<< DATA_FRAC;
  localparam logic signed [DATA_W-1:0] IN_LIM = DATA_W'(201) <<< (DATA_FRAC - 7);
  localparam logic signed [DATA_W-1:0] Y_LOW  = DATA_W'(5)   <<< (DATA_FRAC - 4);
  localparam logic signed [DATA_W-1:0] Y_HIGH = DATA_W'(45)  <<< (DATA_FRAC - 4);

  logic signed [ACC_W-1:0]  acc_p [0:NSTAGE];
  logic signed [DATA_W-1:0] x_p   [0:NSTAGE-1];
  logic                     vld_p [0:NSTAGE];

  assign acc_p[0] = ACC_W'(eps_pkg::coef_q(NSTAGE, ACC_FRAC));
  assign x_p[0]   = in_x;
  assign vld_p[0] = in_vld;

  for (genvar d = 1; d < NSTAGE; d++) begin : g_xdly
    always_ff @(posedge clk) x_p[d] <= x_p[d-1];
  end

  for (genvar s = 1; s <= NSTAGE; s++) begin : g_mac
    eps_mac_stage #(
      .ACC_W(ACC_W), .DATA_W(DATA_W), .DATA_FRAC(DATA_FRAC),
      .COEF(ACC_W'(eps_pkg::coef_q(NSTAGE - s, ACC_FRAC)))
    ) mac_i (
      .clk(clk), .rst(rst), .vld_i(vld_p[s-1]), .x_i(x_p[s-1]),
      .acc_i(acc_p[s-1]), .vld_o(vld_p[s]), .acc_o(acc_p[s])
    );
  end

  eps_round_sat #(
    .ACC_W(ACC_W), .ACC_FRAC(ACC_FRAC), .DATA_W(DATA_W), .DATA_FRAC(DATA_FRAC)
  ) fin_i (
    .clk(clk), .rst(rst), .vld_i(vld_p[NSTAGE]), .acc_i(acc_p[NSTAGE]),
    .vld_o(out_vld), .y_o(out_y)
  );

  // cycles since reset, saturating at the pipeline depth; used by the checks below
  logic [CNT_W-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                            since_rst <= '0;
    else if (since_rst != CNT_W'(LAT))  since_rst <= since_rst + 1'b1;
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CNT_W'(LAT)) |-> (out_vld == $past(in_vld, LAT))); // R5

  AST_ZERO_EXACT: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CNT_W'(LAT) && out_vld && $past(in_x, LAT) == '0) |-> (out_y == ONE)); // R3

  AST_RESULT_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (since_rst == CNT_W'(LAT) && out_vld && $past(in_x, LAT) <= IN_LIM && $past(in_x, LAT) >= -IN_LIM)
    |-> (out_y >= Y_LOW && out_y <= Y_HIGH)); // R8

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_vld); // R7

endmodule

// File: tb/exp_sine_eval_tb_top.sv
module exp_sine_eval_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [15:0] in_x = '0;
  logic out_vld;
  logic signed [15:0] out_y;

  always #5 clk = ~clk;

  exp_sine_eval dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_x(in_x),
    .out_vld(out_vld), .out_y(out_y)
  );

  int n_chk = 0;
  int n_fail = 0;
  int t = 0;
  bit done = 1'b0;
  string cur_tag = "R6";

  bit          ring_v   [8];
  logic [15:0] ring_x   [8];
  string       ring_tag [8];

  localparam int IN_MAX = 12867;

  task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d (t=%0d)", tag, what, got, exp, t);
    end
  endtask

  function automatic int exp_code(input int raw);
    real xr, p, y;
    xr = real'(raw) / 8192.0;
    p = 1.0 + xr + xr*xr/2.0 - (xr**4)/8.0 - (xr**5)/15.0 - (xr**6)/240.0;
    y = $floor(p * 8192.0 + 0.5);
    if (y > 32767.0)  y = 32767.0;
    if (y < -32768.0) y = -32768.0;
    return $rtoi(y);
  endfunction

  task automatic check_data(input logic signed [15:0] x, input logic signed [15:0] y);
    int xi, yi, e, d;
    xi = int'(x);
    yi = int'(y);
    e = exp_code(xi);
    d = yi - e;
    if (d < 0) d = -d;
    if (xi == 0)
      chk(yi == 8192, "R3", "zero input result", yi, 8192);
    else if (xi > IN_MAX || xi < -IN_MAX)
      chk(yi == e, "R4", "saturated result", yi, e);
    else if (xi == 8192)
      chk(d <= 2, "R1", "result for 1.0", yi, e);
    else
      chk(d <= 2, "R2", "series result", yi, e);
    if (xi <= IN_MAX && xi >= -IN_MAX)
      chk(yi >= 2560 && yi <= 23040, "R8", "result window", yi, e);
  endtask

  task automatic step(input bit v, input logic signed [15:0] x, input bit r);
    int slot, nslot;
    @(negedge clk);
    slot = t % 8;
    chk(out_vld == ring_v[slot], ring_tag[slot], "out_vld", int'(out_vld), int'(ring_v[slot]));
    if (ring_v[slot] && out_vld) check_data(ring_x[slot], out_y);
    rst = r;
    in_vld = v;
    in_x = x;
    if (r) begin
      for (int k = 0; k < 8; k++) begin
        ring_v[k] = 1'b0;
        ring_tag[k] = "R7";
      end
    end
    nslot = (t + 7) % 8;
    ring_v[nslot] = v && !r;
    ring_x[nslot] = x;
    ring_tag[nslot] = r ? "R7" : cur_tag;
    t++;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      ring_v[k] = 1'b0;
      ring_x[k] = '0;
      ring_tag[k] = "R7";
    end
    // reset, then idle: no result may appear (R7)
    for (int k = 0; k < 4; k++) step(1'b1, 16'sd100, 1'b1);
    for (int k = 0; k < 8; k++) step(1'b0, 16'sd0, 1'b0);
    // every in-range input, back to back (R2, R6)
    cur_tag = "R6";
    for (int i = -IN_MAX; i <= IN_MAX; i++) step(1'b1, 16'(i), 1'b0);
    // exact points and saturation (R1, R3, R4)
    step(1'b1, 16'sh0000, 1'b0);
    step(1'b1, 16'sh2000, 1'b0);
    step(1'b1, 16'sh8000, 1'b0);
    step(1'b1, 16'sh7FFF, 1'b0);
    step(1'b1, -16'sh2000, 1'b0);
    // gapped strobe pattern keeps its shape seven edges later (R5)
    cur_tag = "R5";
    for (int i = 0; i < 300; i++) step((i % 3) != 0, 16'(i * 83 - 12000), 1'b0);
    for (int i = 0; i < 40; i++) step((i % 5) == 1, 16'(i * 301 - 6000), 1'b0);
    // reset in the middle of a burst discards in-flight samples (R7)
    cur_tag = "R6";
    for (int i = 0; i < 5; i++) step(1'b1, 16'(i * 1000), 1'b0);
    step(1'b1, 16'sd4000, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b0, 16'sd0, 1'b0);
    cur_tag = "R5";
    step(1'b1, 16'sd0, 1'b0);
    for (int i = 0; i < 10; i++) step(1'b0, 16'sd0, 1'b0);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", 200000);
      finish_run();
    end
  end

endmodule